// File: doc/BRIEF.md
# Weighted Table-Driven Route Computation Unit

This unit performs route computation for one router of a flit-based wormhole network. When the head flit of a packet reaches the front of an ingress virtual channel, the router presents the packet's previous node ID and flow ID as a lookup request. The pair addresses a programmable table. Each table entry holds a small set of candidate next hops, and each candidate carries an egress node, a replacement flow ID and a weight. The unit picks one candidate at random, with odds in proportion to the weights. It answers with the chosen egress node and the renamed flow ID. Body and tail flits keep the head's result, so the router issues exactly one lookup per packet.

Each candidate is written into the table one at a time through a configuration port. Randomness comes from a 16-bit linear feedback shift register whose state can be reloaded from a seed. Reloading the seed makes a run repeat exactly. A deterministic route is a single candidate. A two-way split is two candidates of equal weight. Renaming the flow lets a two-phase route record that it has passed its intermediate node, and restore the original ID at the end. When the chosen node equals the router's own ID, the packet is to eject to the local port.

Top module: `wrc_top`

## Requirements
- R1: A configuration write with `cfg_we` high stores the candidate fields (valid, node, flow, weight) into slot `cfg_slot` of the entry addressed by {`cfg_prev`,`cfg_flow`}. Later lookups of that entry see the new contents.
- R2: A lookup is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending or `rsp_ready` is high. An accepted lookup with a non-zero weight sum produces `rsp_valid` high right after that same edge.
- R3: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged. `req_ready` stays low during that time, so no lookup is accepted.
- R4: Let L be the LFSR state at acceptance, and let S be the sum of the weights of the valid candidates in the entry. Let r = L mod S. The chosen slot is the lowest valid slot i for which the running sum of valid weights over slots 0..i is greater than r. `rsp_slot` reports i.
- R5: A candidate whose valid bit is clear, or whose weight is zero, is never chosen.
- R6: `rsp_next_flow` and `rsp_next_node` carry the chosen candidate's replacement flow ID and node ID.
- R7: `rsp_eject` is high exactly when the chosen node ID equals the `self_id` input.
- R8: The LFSR shifts left by one bit and takes in the feedback bit s[15]^s[13]^s[12]^s[10]. It advances once per accepted lookup and at no other time. A pulse on `seed_we` loads `seed_val`, or 1 if `seed_val` is zero. The load has priority over an advance.
- R9: An accepted lookup whose weight sum S is zero produces no response and sets `err_flag`. The flag then stays set until reset.
- R10: After reset no response is pending, `err_flag` is low, `req_ready` is high, every table candidate is invalid, and the LFSR holds the parameter `RESET_SEED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | NODE_W | This router's node ID |
| cfg_we | input | 1 | Table candidate write strobe |
| cfg_prev | input | NODE_W | Previous-node part of the write index |
| cfg_flow | input | FLOW_W | Flow part of the write index |
| cfg_slot | input | $clog2(CAND_N) | Candidate slot to write |
| cfg_valid | input | 1 | Valid bit of the written candidate |
| cfg_next_node | input | NODE_W | Egress node of the written candidate |
| cfg_next_flow | input | FLOW_W | Replacement flow ID of the written candidate |
| cfg_weight | input | WGT_W | Weight of the written candidate |
| seed_we | input | 1 | Load strobe for the LFSR seed |
| seed_val | input | 16 | Seed value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Unit can accept a lookup |
| req_prev | input | NODE_W | Previous node ID of the packet |
| req_flow | input | FLOW_W | Flow ID of the packet |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_next_node | output | NODE_W | Chosen egress node |
| rsp_next_flow | output | FLOW_W | Renamed flow ID |
| rsp_eject | output | 1 | Chosen node is this router |
| rsp_slot | output | $clog2(CAND_N) | Index of the chosen candidate |
| err_flag | output | 1 | Sticky flag for a lookup that had no usable candidate |

## Verification
The bench builds entries that probe the cumulative compare at its edges.
- **Gap in the middle.** One entry has an invalid slot and a zero-weight slot between two valid ones. A design that counted invalid weights, or compared with less-or-equal, would sometimes return a dead slot or shift the odds.
- **Equal split.** An entry with two equal-weight candidates must yield both outcomes, each in the exact order the bench's own LFSR model predicts. A wrong polynomial or a wrong advance rule desynchronises the sequence.
- **Stalled request.** A request held off by back-pressure must not advance the LFSR. An empty entry must raise the sticky flag and emit nothing, where a faulty design would hand out a stale or garbage route.
- **Seed reload and rename.** Reloading the same seed must replay an identical sequence. Renamed flows and ejection at the own node ID are checked on every response.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

   localparam int RND_W = 16;

   // One shift of the 16-bit maximal-length register (taps 16,14,13,11).
   function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
      return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

endpackage

// File: rtl/wrc_lfsr.sv
module wrc_lfsr
   import wrc_pkg::*;
#(
   parameter logic [RND_W-1:0] RESET_SEED = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RND_W-1:0] seed,
   input  logic             adv,
   output logic [RND_W-1:0] state
);

   initial begin
      assert (RESET_SEED != '0) else $fatal(1, "RESET_SEED must be non-zero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= RESET_SEED;
      else if (load)
         state <= (seed == '0) ? RND_W'(1) : seed;
      else if (adv)
         state <= rnd_step(state);
   end

   // R8: an all-zero state would lock the generator
   assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/wrc_table.sv
module wrc_table #(
   parameter int NODE_W = 4,
   parameter int FLOW_W = 4,
   parameter int CAND_N = 4,
   parameter int WGT_W  = 8,
   localparam int IDX_W  = NODE_W + FLOW_W,
   localparam int DEPTH  = 1 << IDX_W,
   localparam int CW     = 1 + NODE_W + FLOW_W + WGT_W,
   localparam int SLOT_W = $clog2(CAND_N)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [SLOT_W-1:0]          wr_slot,
   input  logic [CW-1:0]              wr_data,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [CAND_N-1:0][CW-1:0]  rd_data
);

   initial begin
      assert (IDX_W <= 10) else $fatal(1, "table index too wide");
   end

   for (genvar g = 0; g < CAND_N; g++) begin : g_slot
      logic [CW-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
         end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
            mem[wr_idx] <= wr_data;
         end
      end

      assign rd_data[g] = mem[rd_idx];

      // R1: a write to this slot is visible on the next read of that index
      assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_slot == SLOT_W'(g) && rd_idx == wr_idx) |=>
            (rd_idx != $past(wr_idx)) || (rd_data[g] == $past(wr_data)));
   end

endmodule

// File: rtl/wrc_pick.sv
module wrc_pick
   import wrc_pkg::*;
#(
   parameter int NODE_W = 4,
   parameter int FLOW_W = 4,
   parameter int CAND_N = 4,
   parameter int WGT_W  = 8,
   localparam int CW     = 1 + NODE_W + FLOW_W + WGT_W,
   localparam int SLOT_W = $clog2(CAND_N),
   localparam int SUM_W  = WGT_W + SLOT_W
) (
   input  logic [CAND_N-1:0][CW-1:0] cands,
   input  logic [RND_W-1:0]          rnd,
   output logic                      any,
   output logic [SLOT_W-1:0]         sel
);

   initial begin
      assert (SUM_W <= RND_W) else $fatal(1, "weight sum wider than random word");
   end

   logic [CAND_N-1:0] usable;
   logic [SUM_W-1:0]  total;
   logic [RND_W-1:0]  rem;
   logic [SUM_W-1:0]  draw;

   for (genvar g = 0; g < CAND_N; g++) begin : g_use
      assign usable[g] = cands[g][CW-1] && (cands[g][WGT_W-1:0] != '0);
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < CAND_N; i++)
         if (usable[i]) total = total + SUM_W'(cands[i][WGT_W-1:0]);
   end

   assign any  = (total != '0);
   assign rem  = any ? (rnd % RND_W'(total)) : '0;
   assign draw = rem[SUM_W-1:0];

   always_comb begin
      logic [SUM_W-1:0] run;
      logic             hit;
      run = '0;
      hit = 1'b0;
      sel = '0;
      for (int i = 0; i < CAND_N; i++) begin
         if (usable[i]) begin
            run = run + SUM_W'(cands[i][WGT_W-1:0]);
            if (!hit && (draw < run)) begin
               sel = SLOT_W'(i);
               hit = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/wrc_top.sv
module wrc_top
   import wrc_pkg::*;
#(
   parameter int NODE_W = 4,
   parameter int FLOW_W = 4,
   parameter int CAND_N = 4,
   parameter int WGT_W  = 8,
   parameter logic [RND_W-1:0] RESET_SEED = 16'hACE1,
   localparam int SLOT_W = $clog2(CAND_N),
   localparam int IDX_W  = NODE_W + FLOW_W,
   localparam int CW     = 1 + NODE_W + FLOW_W + WGT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NODE_W-1:0]  self_id,
   input  logic               cfg_we,
   input  logic [NODE_W-1:0]  cfg_prev,
   input  logic [FLOW_W-1:0]  cfg_flow,
   input  logic [SLOT_W-1:0]  cfg_slot,
   input  logic               cfg_valid,
   input  logic [NODE_W-1:0]  cfg_next_node,
   input  logic [FLOW_W-1:0]  cfg_next_flow,
   input  logic [WGT_W-1:0]   cfg_weight,
   input  logic               seed_we,
   input  logic [RND_W-1:0]   seed_val,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [NODE_W-1:0]  req_prev,
   input  logic [FLOW_W-1:0]  req_flow,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [NODE_W-1:0]  rsp_next_node,
   output logic [FLOW_W-1:0]  rsp_next_flow,
   output logic               rsp_eject,
   output logic [SLOT_W-1:0]  rsp_slot,
   output logic               err_flag
);

   initial begin
      assert (CAND_N >= 2 && CAND_N <= 8) else $fatal(1, "CAND_N out of range");
      assert (NODE_W >= 1 && FLOW_W >= 1 && WGT_W >= 1) else $fatal(1, "bad field width");
   end

   logic                      acc;
   logic [RND_W-1:0]          rnd;
   logic [CAND_N-1:0][CW-1:0] cands;
   logic                      pk_any;
   logic [SLOT_W-1:0]         pk_sel;
   logic [CW-1:0]             chosen;
   logic [NODE_W-1:0]         ch_node;
   logic [FLOW_W-1:0]         ch_flow;

   assign req_ready = !rsp_valid || rsp_ready;
   assign acc       = req_valid && req_ready;

   wrc_table #(.NODE_W(NODE_W), .FLOW_W(FLOW_W), .CAND_N(CAND_N), .WGT_W(WGT_W)) table_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_idx  ({cfg_prev, cfg_flow}),
      .wr_slot (cfg_slot),
      .wr_data ({cfg_valid, cfg_next_node, cfg_next_flow, cfg_weight}),
      .rd_idx  ({req_prev, req_flow}),
      .rd_data (cands)
   );

   wrc_lfsr #(.RESET_SEED(RESET_SEED)) lfsr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seed_we),
      .seed  (seed_val),
      .adv   (acc),
      .state (rnd)
   );

   wrc_pick #(.NODE_W(NODE_W), .FLOW_W(FLOW_W), .CAND_N(CAND_N), .WGT_W(WGT_W)) pick_i (
      .cands (cands),
      .rnd   (rnd),
      .any   (pk_any),
      .sel   (pk_sel)
   );

   assign chosen  = cands[pk_sel];
   assign ch_node = chosen[WGT_W+FLOW_W +: NODE_W];
   assign ch_flow = chosen[WGT_W +: FLOW_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_next_node <= '0;
         rsp_next_flow <= '0;
         rsp_eject     <= 1'b0;
         rsp_slot      <= '0;
         err_flag      <= 1'b0;
      end else if (acc) begin
         rsp_valid <= pk_any;
         if (pk_any) begin
            rsp_next_node <= ch_node;
            rsp_next_flow <= ch_flow;
            rsp_eject     <= (ch_node == self_id);
            rsp_slot      <= pk_sel;
         end else begin
            err_flag <= 1'b1;
         end
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   // R2: every accepted lookup yields a response or an error on the next cycle
   assert_answer_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (rsp_valid || err_flag));

   // R2: a response only appears after an accepted lookup
   assert_rsp_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(acc));

   // R3: a stalled response holds its fields
   assert_rsp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_next_node) &&
         $stable(rsp_next_flow) && $stable(rsp_slot) && $stable(rsp_eject)));

   // R5: the picker never lands on a dead candidate
   assert_pick_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && pk_any) |-> (chosen[CW-1] && chosen[WGT_W-1:0] != '0));

   // R9: the error flag is sticky
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

endmodule

// File: tb/wrc_top_tb_top.sv
module wrc_top_tb_top;

   localparam int CLK_T = 10;
   localparam int NW = 4;
   localparam int FW = 4;
   localparam int CN = 4;
   localparam int WW = 8;
   localparam logic [15:0] RSEED = 16'hACE1;

   typedef struct {
      logic [NW-1:0] node;
      logic [FW-1:0] flow;
      logic          ej;
      int            slot;
      string         tag;
   } exp_t;

   logic clk = 0;
   logic rst_n = 0;
   logic [NW-1:0] self_id = 4'd5;
   logic cfg_we = 0;
   logic [NW-1:0] cfg_prev = 0;
   logic [FW-1:0] cfg_flow = 0;
   logic [1:0] cfg_slot = 0;
   logic cfg_valid = 0;
   logic [NW-1:0] cfg_next_node = 0;
   logic [FW-1:0] cfg_next_flow = 0;
   logic [WW-1:0] cfg_weight = 0;
   logic seed_we = 0;
   logic [15:0] seed_val = 0;
   logic req_valid = 0;
   logic req_ready;
   logic [NW-1:0] req_prev = 0;
   logic [FW-1:0] req_flow = 0;
   logic rsp_valid;
   logic rsp_ready = 1;
   logic [NW-1:0] rsp_next_node;
   logic [FW-1:0] rsp_next_flow;
   logic rsp_eject;
   logic [1:0] rsp_slot;
   logic err_flag;

   wrc_top dut_i (
      .clk(clk), .rst_n(rst_n), .self_id(self_id),
      .cfg_we(cfg_we), .cfg_prev(cfg_prev), .cfg_flow(cfg_flow), .cfg_slot(cfg_slot),
      .cfg_valid(cfg_valid), .cfg_next_node(cfg_next_node), .cfg_next_flow(cfg_next_flow),
      .cfg_weight(cfg_weight), .seed_we(seed_we), .seed_val(seed_val),
      .req_valid(req_valid), .req_ready(req_ready), .req_prev(req_prev), .req_flow(req_flow),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_next_node(rsp_next_node),
      .rsp_next_flow(rsp_next_flow), .rsp_eject(rsp_eject), .rsp_slot(rsp_slot),
      .err_flag(err_flag)
   );

   always #(CLK_T/2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   exp_t sb[$];
   int seen[CN];
   int trace[$];

   // bench-side table and random model
   logic          m_v [256][CN];
   logic [NW-1:0] m_n [256][CN];
   logic [FW-1:0] m_f [256][CN];
   logic [WW-1:0] m_w [256][CN];
   logic [15:0]   m_rnd = RSEED;

   function automatic logic [15:0] nxt(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cfg(input int p, input int f, input int s, input bit v,
                      input int nn, input int nf, input int w);
      @(posedge clk); #1;
      cfg_we = 1; cfg_prev = NW'(p); cfg_flow = FW'(f); cfg_slot = 2'(s);
      cfg_valid = v; cfg_next_node = NW'(nn); cfg_next_flow = FW'(nf); cfg_weight = WW'(w);
      m_v[p*16+f][s] = v; m_n[p*16+f][s] = NW'(nn);
      m_f[p*16+f][s] = FW'(nf); m_w[p*16+f][s] = WW'(w);
      @(posedge clk); #1;
      cfg_we = 0;
   endtask

   task automatic load_seed(input logic [15:0] s);
      @(posedge clk); #1;
      seed_we = 1; seed_val = s;
      m_rnd = (s == 0) ? 16'd1 : s;
      @(posedge clk); #1;
      seed_we = 0;
   endtask

   // driver: predicts the response from the requirements, then issues the lookup
   task automatic lookup(input int p, input int f, input string tag);
      int idx, sum, r, run, pick;
      exp_t e;
      idx = p*16 + f;
      @(posedge clk); #1;
      req_valid = 1; req_prev = NW'(p); req_flow = FW'(f);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      sum = 0;
      for (int i = 0; i < CN; i++) if (m_v[idx][i]) sum += int'(m_w[idx][i]);
      if (sum != 0) begin
         r = int'(m_rnd) % sum;
         run = 0; pick = -1;
         for (int i = 0; i < CN; i++) begin
            if (m_v[idx][i]) begin
               run += int'(m_w[idx][i]);
               if (pick < 0 && m_w[idx][i] != 0 && r < run) pick = i;
            end
         end
         e.node = m_n[idx][pick]; e.flow = m_f[idx][pick];
         e.ej = (m_n[idx][pick] == self_id); e.slot = pick; e.tag = tag;
         sb.push_back(e);
      end
      m_rnd = nxt(m_rnd);
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   // monitor: pops the scoreboard as responses are consumed
   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_ready) begin
         if (sb.size() == 0) begin
            chk(0, "R2", "unexpected response", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rsp_slot == 2'(e.slot), {e.tag, "/R4"}, "slot", int'(rsp_slot), e.slot);
            chk(rsp_next_node == e.node && rsp_next_flow == e.flow, {e.tag, "/R6"},
                "node*16+flow", int'(rsp_next_node)*16 + int'(rsp_next_flow),
                int'(e.node)*16 + int'(e.flow));
            chk(rsp_eject == e.ej, {e.tag, "/R7"}, "eject", int'(rsp_eject), int'(e.ej));
            seen[rsp_slot]++;
            trace.push_back(int'(rsp_slot));
         end
      end
   end

   task automatic clear_seen();
      for (int i = 0; i < CN; i++) seen[i] = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_T * 100000);
      chk(0, "ALL", "watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      int first[$];
      for (int i = 0; i < 256; i++)
         for (int j = 0; j < CN; j++) begin
            m_v[i][j] = 0; m_n[i][j] = 0; m_f[i][j] = 0; m_w[i][j] = 0;
         end
      clear_seen();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R10: reset state
      chk(rsp_valid == 0, "R10", "rsp_valid after reset", int'(rsp_valid), 0);
      chk(err_flag == 0, "R10", "err_flag after reset", int'(err_flag), 0);
      chk(req_ready == 1, "R10", "req_ready after reset", int'(req_ready), 1);

      // R1 R6: deterministic single candidate with flow rename
      cfg(3, 2, 2, 1, 7, 9, 255);
      for (int k = 0; k < 3; k++) lookup(3, 2, "R1");

      // R7: destination entry ejects locally
      cfg(6, 3, 0, 1, 5, 3, 10);
      lookup(6, 3, "R7");

      // R4: equal two-way split
      cfg(5, 1, 0, 1, 4, 1, 128);
      cfg(5, 1, 1, 1, 6, 1, 128);
      repeat (2) @(negedge clk);
      clear_seen();
      for (int k = 0; k < 24; k++) lookup(5, 1, "R4");
      repeat (2) @(negedge clk);
      chk(seen[0] > 0 && seen[1] > 0, "R4", "both split halves used",
          seen[0]*100 + seen[1], 1);

      // R5: invalid slot and zero-weight slot between live ones
      cfg(1, 4, 0, 1, 2, 4, 30);
      cfg(1, 4, 1, 0, 9, 4, 200);
      cfg(1, 4, 2, 1, 10, 4, 0);
      cfg(1, 4, 3, 1, 11, 12, 90);
      repeat (2) @(negedge clk);
      clear_seen();
      for (int k = 0; k < 30; k++) lookup(1, 4, "R5");
      repeat (2) @(negedge clk);
      chk(seen[1] == 0 && seen[2] == 0, "R5", "dead slots chosen",
          seen[1] + seen[2], 0);

      // R3: back-pressure holds response; stalled request does not advance LFSR
      rsp_ready = 0;
      lookup(3, 2, "R3");
      @(posedge clk); #1;
      req_valid = 1; req_prev = 4'd1; req_flow = 4'd4;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(req_ready == 0, "R3", "req_ready while stalled", int'(req_ready), 0);
         chk(rsp_valid == 1 && rsp_next_node == 4'd7 && rsp_next_flow == 4'd9, "R3",
             "held response", int'(rsp_next_node), 7);
      end
      @(posedge clk); #1;
      req_valid = 0; rsp_ready = 1;
      for (int k = 0; k < 6; k++) lookup(1, 4, "R8");

      // R1: overwrite a slot
      cfg(3, 2, 2, 1, 8, 1, 40);
      lookup(3, 2, "R1");

      // R8: reloading a seed replays the sequence
      repeat (2) @(negedge clk);
      load_seed(16'h1234);
      trace.delete();
      for (int k = 0; k < 10; k++) lookup(5, 1, "R8");
      repeat (2) @(negedge clk);
      first = trace;
      load_seed(16'h1234);
      trace.delete();
      for (int k = 0; k < 10; k++) lookup(5, 1, "R8");
      repeat (2) @(negedge clk);
      chk(first == trace, "R8", "replayed sequence matches", trace.size(), first.size());
      load_seed(16'h0000);
      for (int k = 0; k < 4; k++) lookup(1, 4, "R8");

      // R9 R10: empty entry raises sticky error and no response
      lookup(2, 2, "R9");
      @(negedge clk);
      chk(rsp_valid == 0, "R9", "no response for empty entry", int'(rsp_valid), 0);
      chk(err_flag == 1, "R9", "err_flag raised", int'(err_flag), 1);
      lookup(6, 3, "R9");
      repeat (2) @(negedge clk);
      chk(err_flag == 1, "R9", "err_flag sticky", int'(err_flag), 1);

      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
      finish_run();
   end

endmodule